// File: doc/BRIEF.md
# Indexed Configuration Port Decoder

This block watches every I/O cycle a processor core issues and decides whether the cycle is served by a small on-chip configuration register file or sent to the external bus. Software reaches the register file through two byte-wide ports. It first writes an index to the index port at 22h. It then reads or writes the selected entry through the data port at 23h. The index is used once only, and only a value inside the supported index set enables it. Any data-port access that does not directly follow such an index write is sent to the external bus, and the on-chip entries stay as they are.

The decoder also watches a legacy display address window at 3B0h–3DFh. That window is split into three 16-address slices, and each slice has its own enable input. When an I/O cycle starts inside an enabled slice, the block raises a one-cycle request to the system-management interrupt logic.

Each I/O cycle is presented as a single-cycle strobe with its address, direction, size and write data. One clock later the block returns a response pulse. The pulse carries exactly one routing flag (internal or external), the trap flag, and the read data for internal reads.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset every register entry reads as 00h, no index is armed, and all outputs are 0.
- R2: A byte write (size code 0) to 22h whose low data byte lies in C0h–CFh or FEh–FFh is handled internally (`int_hit_o`=1, `ext_cycle_o`=0) and arms that index.
- R3: A byte write to 22h with any other index value is forwarded (`ext_cycle_o`=1), arms nothing and leaves every entry unchanged.
- R4: A byte write to 23h made while an index is armed is handled internally and stores the low data byte into the indexed entry.
- R5: A byte read of 23h made while an index is armed is handled internally and returns the indexed entry on `io_rdata_o[7:0]` with bits 31:8 at zero. Every response that is not an internal read returns zero data.
- R6: A byte access to 23h made with no armed index is forwarded and leaves every entry unchanged.
- R7: An armed index allows exactly one 23h access, read or write. The next 23h access is forwarded unless a new valid index write comes first.
- R8: An access to any address other than 22h or 23h, made between the index write and the data access, disarms the index.
- R9: A read of 22h is always forwarded and disarms the index.
- R10: An access whose size is not a byte (size code 1 = 16 bit, 2 = 32 bit) is forwarded even when it touches 22h or 23h. It neither arms an index nor modifies an entry, and it disarms any armed index.
- R11: The trap is decided from the start address of a valid access. Enable bit 0 covers 3B0h–3BFh, bit 1 covers 3C0h–3CFh and bit 2 covers 3D0h–3DFh. An access inside an enabled slice gives `smi_req_o`=1 for one cycle in its response. Addresses outside 3B0h–3DFh never trap.
- R12: Each access strobed on `io_valid_i` gets `resp_valid_o`=1 in the following cycle, together with exactly one of `int_hit_o` and `ext_cycle_o`. In a cycle that follows no strobe, `resp_valid_o`, `int_hit_o`, `ext_cycle_o` and `smi_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_valid_i | input | 1 | One-cycle strobe marking an I/O cycle |
| io_write_i | input | 1 | 1 = OUT (write), 0 = IN (read) |
| io_addr_i | input | 16 | I/O start address |
| io_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wdata_i | input | 32 | Write data; the index or entry value is in bits 7:0 |
| trap_en_i | input | 3 | Per-slice trap enables for the display window |
| resp_valid_o | output | 1 | Response pulse, one cycle after the strobe |
| int_hit_o | output | 1 | Access handled by the on-chip registers |
| ext_cycle_o | output | 1 | Access to be run as an external I/O cycle |
| smi_req_o | output | 1 | One-cycle trap request |
| io_rdata_o | output | 32 | Read data of an internal data-port read |

## Verification
The checker relies on each I/O cycle arriving as a strobe that lasts one cycle, with address, size, direction and data stable while the strobe is high. It also assumes size code 3 never occurs. It tracks armed state only through the index byte seen on write strobes to 22h, so it relies on the index travelling in bits 7:0. The bench drives each access at the falling edge for exactly one cycle and uses only size codes 0–2. Between accesses it leaves the strobe low for whole cycles, so the quiet-cycle checks see a clean idle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned REG_W     = 8;
  localparam logic [15:0] IDX_PORT  = 16'h0022;
  localparam logic [15:0] DAT_PORT  = 16'h0023;
  localparam logic [7:0]  LO_BASE   = 8'hC0;
  localparam int unsigned LO_CNT    = 16;
  localparam logic [7:0]  HI_BASE   = 8'hFE;
  localparam int unsigned HI_CNT    = 2;
  localparam logic [15:0] TRAP_BASE = 16'h03B0;
  localparam int unsigned TRAP_SPAN = 16;
  localparam int unsigned TRAP_NSUB = 3;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  function automatic logic idx_ok(input logic [7:0] idx);
    logic [8:0] v;
    v = {1'b0, idx};
    return ((v >= 9'(LO_BASE)) && (v < 9'(LO_BASE) + 9'(LO_CNT))) ||
           ((v >= 9'(HI_BASE)) && (v < 9'(HI_BASE) + 9'(HI_CNT)));
  endfunction
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h0022,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h0023,
  parameter logic [7:0]  LO_BASE  = 8'hC0,
  parameter int unsigned LO_CNT   = 16,
  parameter logic [7:0]  HI_BASE  = 8'hFE,
  parameter int unsigned HI_CNT   = 2,
  localparam int unsigned NREG    = LO_CNT + HI_CNT,
  localparam int unsigned SLOT_W  = $clog2(NREG)
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [7:0]        idx_i,
  input  logic              armed_i,
  output logic              arm_set_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic              go_int_o,
  output logic              go_ext_o
);
  logic [8:0] idx9;
  logic       lo_hit, hi_hit, is_byte, dat_acc;

  assign idx9    = {1'b0, idx_i};
  assign lo_hit  = (idx9 >= 9'(LO_BASE)) && (idx9 < 9'(LO_BASE) + 9'(LO_CNT));
  assign hi_hit  = (idx9 >= 9'(HI_BASE)) && (idx9 < 9'(HI_BASE) + 9'(HI_CNT));
  assign is_byte = (size_i == 2'd0);

  // low block first, high block packed after it
  assign slot_o = lo_hit ? SLOT_W'(idx9 - 9'(LO_BASE))
                         : SLOT_W'(idx9 - 9'(HI_BASE) + 9'(LO_CNT));

  assign arm_set_o = valid_i && write_i && is_byte && (addr_i == IDX_ADDR) && (lo_hit || hi_hit);
  assign dat_acc   = valid_i && is_byte && (addr_i == DAT_ADDR) && armed_i;
  assign reg_we_o  = dat_acc && write_i;
  assign reg_re_o  = dat_acc && !write_i;
  assign go_int_o  = arm_set_o || dat_acc;
  assign go_ext_o  = valid_i && !go_int_o;
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int unsigned NREG   = 18,
  parameter int unsigned REG_W  = 8,
  localparam int unsigned SLOT_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ent_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (we_i && (slot_i == SLOT_W'(g)))       ent_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (slot_i == SLOT_W'(i)) rdata_o = ent_q[i];
    end
  end
endmodule

// File: rtl/cfgp_trap.sv
module cfgp_trap #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] TRAP_BASE = 16'h03B0,
  parameter int unsigned TRAP_SPAN = 16,
  parameter int unsigned TRAP_NSUB = 3
) (
  input  logic                 valid_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [TRAP_NSUB-1:0] en_i,
  output logic                 hit_o
);
  logic [TRAP_NSUB-1:0] sub_hit;

  for (genvar g = 0; g < TRAP_NSUB; g++) begin : g_sub
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(TRAP_BASE) + (ADDR_W+1)'(g * TRAP_SPAN);
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(TRAP_SPAN);
    assign sub_hit[g] = en_i[g] && ({1'b0, addr_i} >= LO) && ({1'b0, addr_i} < HI);
  end

  assign hit_o = valid_i && (|sub_hit);
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder import cfgp_pkg::*; #(
  parameter int unsigned ADDR_W    = cfgp_pkg::ADDR_W,
  parameter int unsigned DATA_W    = cfgp_pkg::DATA_W,
  parameter int unsigned REG_W     = cfgp_pkg::REG_W,
  parameter logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(IDX_PORT),
  parameter logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(DAT_PORT),
  parameter logic [7:0]  IDX_LO    = LO_BASE,
  parameter int unsigned IDX_LO_N  = LO_CNT,
  parameter logic [7:0]  IDX_HI    = HI_BASE,
  parameter int unsigned IDX_HI_N  = HI_CNT,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = ADDR_W'(TRAP_BASE),
  parameter int unsigned TRAP_W    = TRAP_SPAN,
  parameter int unsigned TRAP_N    = TRAP_NSUB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_valid_i,
  input  logic              io_write_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [1:0]        io_size_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  input  logic [TRAP_N-1:0] trap_en_i,
  output logic              resp_valid_o,
  output logic              int_hit_o,
  output logic              ext_cycle_o,
  output logic              smi_req_o,
  output logic [DATA_W-1:0] io_rdata_o
);
  localparam int unsigned NREG   = IDX_LO_N + IDX_HI_N;
  localparam int unsigned SLOT_W = $clog2(NREG);

  logic              armed_q;
  logic [SLOT_W-1:0] slot_q, dec_slot;
  logic              arm_set, reg_we, reg_re, go_int, go_ext, trap_hit;
  logic [REG_W-1:0]  rd_byte;
  logic              unused_wdata;

  assign unused_wdata = ^io_wdata_i[DATA_W-1:REG_W];

  cfgp_decode #(
    .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR),
    .LO_BASE(IDX_LO), .LO_CNT(IDX_LO_N), .HI_BASE(IDX_HI), .HI_CNT(IDX_HI_N)
  ) u_dec (
    .valid_i  (io_valid_i),
    .write_i  (io_write_i),
    .addr_i   (io_addr_i),
    .size_i   (io_size_i),
    .idx_i    (io_wdata_i[7:0]),
    .armed_i  (armed_q),
    .arm_set_o(arm_set),
    .slot_o   (dec_slot),
    .reg_we_o (reg_we),
    .reg_re_o (reg_re),
    .go_int_o (go_int),
    .go_ext_o (go_ext)
  );

  cfgp_regfile #(.NREG(NREG), .REG_W(REG_W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .slot_i (slot_q),
    .wdata_i(io_wdata_i[REG_W-1:0]),
    .rdata_o(rd_byte)
  );

  cfgp_trap #(
    .ADDR_W(ADDR_W), .TRAP_BASE(TRAP_ADDR), .TRAP_SPAN(TRAP_W), .TRAP_NSUB(TRAP_N)
  ) u_trap (
    .valid_i(io_valid_i),
    .addr_i (io_addr_i),
    .en_i   (trap_en_i),
    .hit_o  (trap_hit)
  );

  // index latch: set by a valid index write, cleared by any other access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      slot_q  <= '0;
    end else if (io_valid_i) begin
      armed_q <= arm_set;
      if (arm_set) slot_q <= dec_slot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      int_hit_o    <= 1'b0;
      ext_cycle_o  <= 1'b0;
      smi_req_o    <= 1'b0;
      io_rdata_o   <= '0;
    end else begin
      resp_valid_o <= io_valid_i;
      int_hit_o    <= go_int;
      ext_cycle_o  <= go_ext;
      smi_req_o    <= trap_hit;
      io_rdata_o   <= reg_re ? DATA_W'(rd_byte) : '0;
    end
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker import cfgp_pkg::*; (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_valid_i,
  input logic        io_write_i,
  input logic [15:0] io_addr_i,
  input logic [1:0]  io_size_i,
  input logic [7:0]  idx_i,
  input logic        resp_valid_o,
  input logic        int_hit_o,
  input logic        ext_cycle_o,
  input logic        smi_req_o,
  input logic [31:0] io_rdata_o
);
  logic chk_armed_q;
  logic byte_acc, idx_wr;

  assign byte_acc = io_valid_i && (io_size_i == SZ_BYTE);
  assign idx_wr   = byte_acc && io_write_i && (io_addr_i == IDX_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chk_armed_q <= 1'b0;
    else if (io_valid_i) chk_armed_q <= idx_wr && idx_ok(idx_i);
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i |=> resp_valid_o); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_valid_i |=> !(resp_valid_o || int_hit_o || ext_cycle_o || smi_req_o)); // R12
  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ($countones({int_hit_o, ext_cycle_o}) == 1)); // R12
  AST_GOOD_IDX_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && idx_ok(idx_i)) |=> int_hit_o); // R2
  AST_BAD_IDX_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && !idx_ok(idx_i)) |=> ext_cycle_o); // R3
  AST_ARMED_DATA_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_acc && (io_addr_i == DAT_PORT) && chk_armed_q) |=> int_hit_o); // R4
  AST_UNARMED_DATA_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_acc && (io_addr_i == DAT_PORT) && !chk_armed_q) |=> ext_cycle_o); // R6
  AST_IDX_READ_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_i && !io_write_i && (io_addr_i == IDX_PORT)) |=> ext_cycle_o); // R9
  AST_WIDE_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_i && (io_size_i != SZ_BYTE)) |=> ext_cycle_o); // R10
  AST_RDATA_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (io_rdata_o[31:8] == 24'h0)); // R5
  AST_RDATA_EXT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cycle_o |-> (io_rdata_o == 32'h0)); // R5
  AST_NO_TRAP_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_i && ((io_addr_i < 16'h03B0) || (io_addr_i >= 16'h03E0))) |=> !smi_req_o); // R11
endmodule

bind cfg_port_decoder cfgp_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_valid_i  (io_valid_i),
  .io_write_i  (io_write_i),
  .io_addr_i   (io_addr_i),
  .io_size_i   (io_size_i),
  .idx_i       (io_wdata_i[7:0]),
  .resp_valid_o(resp_valid_o),
  .int_hit_o   (int_hit_o),
  .ext_cycle_o (ext_cycle_o),
  .smi_req_o   (smi_req_o),
  .io_rdata_o  (io_rdata_o)
);

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_valid_i = 1'b0;
  logic        io_write_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [1:0]  io_size_i = '0;
  logic [31:0] io_wdata_i = '0;
  logic [2:0]  trap_en_i = '0;
  logic        resp_valid_o, int_hit_o, ext_cycle_o, smi_req_o;
  logic [31:0] io_rdata_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [256];
  bit         armed_m = 1'b0;
  logic [7:0] cur_idx = '0;

  always #2 clk_i = ~clk_i;

  cfg_port_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .io_valid_i(io_valid_i), .io_write_i(io_write_i),
    .io_addr_i(io_addr_i), .io_size_i(io_size_i), .io_wdata_i(io_wdata_i),
    .trap_en_i(trap_en_i), .resp_valid_o(resp_valid_o), .int_hit_o(int_hit_o),
    .ext_cycle_o(ext_cycle_o), .smi_req_o(smi_req_o), .io_rdata_o(io_rdata_o)
  );

  function automatic bit vidx(input logic [7:0] i);
    return (i >= 8'hC0 && i <= 8'hCF) || (i >= 8'hFE);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // one access; called at a falling edge, returns at a falling edge
  task automatic io(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                    input logic [31:0] d, input string req);
    bit ok, dat, e_int, e_smi;
    logic [31:0] e_rd;
    ok    = (sz == 2'd0) && wr && (a == 16'h0022) && vidx(d[7:0]);
    dat   = (sz == 2'd0) && (a == 16'h0023) && armed_m;
    e_int = ok || dat;
    e_rd  = (dat && !wr) ? {24'h0, shadow[cur_idx]} : 32'h0;
    e_smi = (a >= 16'h03B0) && (a < 16'h03E0) && trap_en_i[(a - 16'h03B0) >> 4];
    if (dat && wr) shadow[cur_idx] = d[7:0];
    if (ok) cur_idx = d[7:0];
    armed_m = ok;
    io_valid_i = 1'b1; io_write_i = wr; io_addr_i = a; io_size_i = sz; io_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    io_valid_i = 1'b0;
    chk(req, "resp_valid", {31'h0, resp_valid_o}, 32'h1);
    chk(req, "int_hit", {31'h0, int_hit_o}, {31'h0, e_int});
    chk(req, "ext_cycle", {31'h0, ext_cycle_o}, {31'h0, !e_int});
    chk(req, "rdata", io_rdata_o, e_rd);
    chk(req, "smi_req", {31'h0, smi_req_o}, {31'h0, e_smi});
  endtask

  task automatic idle(input string req);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req, "idle outputs", {28'h0, resp_valid_o, int_hit_o, ext_cycle_o, smi_req_o}, 32'h0);
  endtask

  task automatic read_entry(input logic [7:0] i, input string req);
    io(1'b1, 16'h0022, 2'd0, {24'h0, i}, req);
    io(1'b0, 16'h0023, 2'd0, 32'h0, req);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    @(negedge clk_i);
    // R1: reset state at the ports
    chk("R1", "outputs in reset",
        {resp_valid_o, int_hit_o, ext_cycle_o, smi_req_o} == 4'h0 && io_rdata_o == 32'h0 ? 32'h1 : 32'h0, 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R1");
    // R1: unarmed data access right after reset goes out
    io(1'b0, 16'h0023, 2'd0, 32'h0, "R1");
    for (int i = 0; i < 256; i++) if (vidx(8'(i))) read_entry(8'(i), "R1");

    // R2/R3/R4/R6: sweep every index value, then a data write
    for (int i = 0; i < 256; i++) begin
      io(1'b1, 16'h0022, 2'd0, {24'hA5A5A5, 8'(i)}, vidx(8'(i)) ? "R2" : "R3");
      io(1'b1, 16'h0023, 2'd0, {24'hFFFFFF, 8'(i) ^ 8'h5A}, vidx(8'(i)) ? "R4" : "R6");
    end
    // R5: read back all entries; invalid indices must not have touched anything
    for (int i = 0; i < 256; i++) if (vidx(8'(i))) read_entry(8'(i), "R5");

    // R7: single use
    io(1'b1, 16'h0022, 2'd0, 32'hC3, "R7");
    io(1'b1, 16'h0023, 2'd0, 32'h11, "R7");
    io(1'b1, 16'h0023, 2'd0, 32'h22, "R7");
    io(1'b0, 16'h0023, 2'd0, 32'h0, "R7");
    read_entry(8'hC3, "R7");
    io(1'b1, 16'h0022, 2'd0, 32'hFE, "R7");
    io(1'b0, 16'h0023, 2'd0, 32'h0, "R7");
    io(1'b0, 16'h0023, 2'd0, 32'h0, "R7");

    // R8: intervening access elsewhere
    for (int p = 0; p < 4; p++) begin
      io(1'b1, 16'h0022, 2'd0, 32'hC5, "R8");
      io(p[0], (p < 2) ? 16'h0080 : 16'h0024, 2'd0, 32'h77, "R8");
      io(1'b1, 16'h0023, 2'd0, 32'h99, "R8");
    end
    read_entry(8'hC5, "R8");

    // R9: index port reads are external and disarm
    io(1'b0, 16'h0022, 2'd0, 32'h0, "R9");
    io(1'b1, 16'h0022, 2'd0, 32'hCA, "R9");
    io(1'b0, 16'h0022, 2'd0, 32'h0, "R9");
    io(1'b1, 16'h0023, 2'd0, 32'h44, "R9");
    read_entry(8'hCA, "R9");

    // R10: wider accesses touching the ports
    for (int sz = 1; sz < 3; sz++) begin
      io(1'b1, 16'h0022, 2'(sz), 32'h000000C1, "R10");
      io(1'b1, 16'h0023, 2'd0, 32'h3C, "R10");
      io(1'b1, 16'h0022, 2'd0, 32'hC1, "R10");
      io(1'b1, 16'h0023, 2'(sz), 32'h0000ABCD, "R10");
      io(1'b0, 16'h0023, 2'd0, 32'h0, "R10");
      io(1'b1, 16'h0020, 2'(sz), 32'hC1C1C1C1, "R10");
      io(1'b0, 16'h0022, 2'(sz), 32'h0, "R10");
    end
    read_entry(8'hC1, "R10");

    // R11: trap window with each enable pattern
    for (int en = 0; en < 8; en++) begin
      trap_en_i = 3'(en);
      for (int a = 16'h03A8; a < 16'h03E8; a++) io(a[0], 16'(a), 2'(a % 3), 32'h0, "R11");
      idle("R11");
    end
    trap_en_i = 3'b111;
    io(1'b0, 16'h03B0, 2'd0, 32'h0, "R11");
    idle("R12");
    io(1'b1, 16'h03DF, 2'd2, 32'h0, "R11");
    io(1'b1, 16'h03E0, 2'd0, 32'h0, "R11");
    trap_en_i = 3'b000;

    // R12: gaps between accesses stay quiet
    io(1'b1, 16'h0022, 2'd0, 32'hFF, "R12");
    idle("R12");
    idle("R12");
    io(1'b1, 16'h0023, 2'd0, 32'h5E, "R12");
    read_entry(8'hFF, "R12");
    idle("R12");

    summary();
    $finish;
  end
endmodule